// File: doc/BRIEF.md
# Interlaced Display Timing Generator

This block produces the raster timing for a video output that is either interlaced (two fields per frame) or progressive (one field). A free-running pixel counter walks each line and a line counter walks the frame. Horizontal blanking and horizontal sync switch at programmed pixel positions. Vertical blanking and vertical sync switch at programmed points, each given as a line number together with the pixel on that line where the change happens. Field 1 and field 2 each have their own set of these points. The field indicator is set on one programmed line and cleared on another.

The block also reports where the visible picture sits. For the field now being output, a window is given by a line offset, a line count, a pixel offset and a pixel count. While the raster lies inside that window, an enable is high and two image counters give the position relative to the window's top-left corner.

The configuration inputs are expected to stay stable while reset is low. To change them, hold reset, change them, then release reset. Every output is registered and lines up with the frame position shown in the same cycle. Lines are numbered from 1, and pixels and image counters from 0. Field 1 is shown as field = 0 and field 2 as field = 1.

Top module: `video_timing_gen`

## Requirements
- R1: frame_pix goes up by one each clock. In the clock after it equals cfg_line_last, it returns to 0, so a line has cfg_line_last+1 positions.
- R2: frame_line goes up by one in the clock where frame_pix wraps to 0. After line cfg_frame_last it returns to 1. Reset gives frame_pix = 0, frame_line = 1, all flags low, and img_pix = img_line = 0.
- R3: hblank becomes 1 when the position reaches pixel cfg_hblank_on and becomes 0 when it reaches pixel cfg_hblank_off, on every line. It holds its value in between.
- R4: hsync follows the same rule with cfg_hsync_on and cfg_hsync_off.
- R5: vblank becomes 1 when (frame_line, frame_pix) equals the start point of either field, given by cfg_vblank_on_line[f] and cfg_vblank_on_x[f]. It becomes 0 at either field's end point, given by cfg_vblank_off_line[f] and cfg_vblank_off_x[f]. It holds its value otherwise.
- R6: vsync follows the same rule with the cfg_vsync_on_* and cfg_vsync_off_* points.
- R7: field becomes 1 at pixel 0 of line cfg_fld_set_line and becomes 0 at pixel 0 of line cfg_fld_clr_line.
- R8: img_active is 1 exactly when both of these hold, where f is the field value in that cycle: frame_line lies in [cfg_img_line_off[f], cfg_img_line_off[f]+cfg_img_lines[f]), and frame_pix lies in [cfg_img_pix_off[f], cfg_img_pix_off[f]+cfg_img_pixels[f]).
- R9: While img_active is 1, img_pix = frame_pix − cfg_img_pix_off[f] and img_line = frame_line − cfg_img_line_off[f]. While it is 0, both are 0.
- R10: When a flag's on point and off point are the same position, the on point wins and the flag is 1 there.
- R11: Progressive use: if cfg_fld_set_line is larger than cfg_frame_last, field stays 0 and only the field-1 window (index 0) controls img_active.
- R12: The position after reset, line 1 pixel 0, counts as a match only when the raster comes back to it. No edge fires in the reset state itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_line_last | input | PW | Last pixel index of a line |
| cfg_frame_last | input | LW | Last line number of a frame |
| cfg_hblank_on | input | PW | Pixel where hblank rises |
| cfg_hblank_off | input | PW | Pixel where hblank falls |
| cfg_hsync_on | input | PW | Pixel where hsync rises |
| cfg_hsync_off | input | PW | Pixel where hsync falls |
| cfg_vblank_on_line | input | 2×LW | Per-field vblank start line |
| cfg_vblank_on_x | input | 2×PW | Per-field vblank start pixel |
| cfg_vblank_off_line | input | 2×LW | Per-field vblank end line |
| cfg_vblank_off_x | input | 2×PW | Per-field vblank end pixel |
| cfg_vsync_on_line | input | 2×LW | Per-field vsync start line |
| cfg_vsync_on_x | input | 2×PW | Per-field vsync start pixel |
| cfg_vsync_off_line | input | 2×LW | Per-field vsync end line |
| cfg_vsync_off_x | input | 2×PW | Per-field vsync end pixel |
| cfg_fld_set_line | input | LW | Line where field goes to 1 |
| cfg_fld_clr_line | input | LW | Line where field goes to 0 |
| cfg_img_line_off | input | 2×LW | Per-field first image line |
| cfg_img_lines | input | 2×LW | Per-field image line count |
| cfg_img_pix_off | input | 2×PW | Per-field first image pixel |
| cfg_img_pixels | input | 2×PW | Per-field image pixel count |
| frame_pix | output | PW | Pixel position in line |
| frame_line | output | LW | Line number in frame |
| img_pix | output | PW | Pixel position inside image window |
| img_line | output | LW | Line position inside image window |
| hblank | output | 1 | Horizontal blanking |
| hsync | output | 1 | Horizontal sync |
| vblank | output | 1 | Vertical blanking |
| vsync | output | 1 | Vertical sync |
| field | output | 1 | Field indicator (0 = field 1) |
| img_active | output | 1 | Inside the current field's image window |

## Verification
The hardest situations to create are the ones tied to the field in effect. One is a field-2 image window that must stay dark while the field indicator is low. Another is a vertical edge whose position falls on the line that also changes the field. Both happen only once per frame, and only after the raster has run for many lines. The stimulus therefore runs each small configuration for two full frames and compares every output in every cycle. The configurations include an edge at mid-line, a horizontal on/off pair that falls on the same pixel, a field-set line beyond the frame, and an image window that reaches the last pixel of a line.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
    // Default counter widths
    localparam int PIX_W  = 12;
    localparam int LINE_W = 11;
    // Fields per frame
    localparam int NFIELD = 2;

    // Flags held in set/clear registers
    typedef enum int {
        FL_HBLANK = 0,
        FL_HSYNC  = 1,
        FL_VBLANK = 2,
        FL_VSYNC  = 3,
        FL_FIELD  = 4
    } flag_idx_e;
    localparam int NFLAG = 5;

    // Per-flag request for the next position
    typedef struct packed {
        logic on;
        logic off;
    } edge_req_t;
endpackage

// File: rtl/vtg_raster.sv
module vtg_raster #(
    parameter int PW = 12,
    parameter int LW = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] cfg_line_last,
    input  logic [LW-1:0] cfg_frame_last,
    output logic [PW-1:0] pix_q,
    output logic [LW-1:0] line_q,
    output logic [PW-1:0] pix_n,
    output logic [LW-1:0] line_n
);
    localparam logic [LW-1:0] FIRST_LINE = LW'(1);

    logic wrap;

    always_comb begin
        wrap   = (pix_q == cfg_line_last);
        pix_n  = wrap ? '0 : pix_q + 1'b1;
        line_n = line_q;
        if (wrap) begin
            line_n = (line_q == cfg_frame_last) ? FIRST_LINE : line_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pix_q  <= '0;
            line_q <= FIRST_LINE;
        end else begin
            pix_q  <= pix_n;
            line_q <= line_n;
        end
    end
endmodule

// File: rtl/vtg_edge_flag.sv
module vtg_edge_flag
    import vtg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  edge_req_t req,
    output logic      d,
    output logic      q
);
    // The on point takes priority over a coinciding off point
    always_comb begin
        d = q;
        if (req.off) d = 1'b0;
        if (req.on)  d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= d;
    end
endmodule

// File: rtl/vtg_image_window.sv
module vtg_image_window
    import vtg_pkg::*;
#(
    parameter int PW = 12,
    parameter int LW = 11
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [PW-1:0]             pix_n,
    input  logic [LW-1:0]             line_n,
    input  logic                      fld_n,
    input  logic [NFIELD-1:0][LW-1:0] cfg_img_line_off,
    input  logic [NFIELD-1:0][LW-1:0] cfg_img_lines,
    input  logic [NFIELD-1:0][PW-1:0] cfg_img_pix_off,
    input  logic [NFIELD-1:0][PW-1:0] cfg_img_pixels,
    output logic                      active,
    output logic [PW-1:0]             img_pix,
    output logic [LW-1:0]             img_line
);
    logic [LW-1:0] rel_line;
    logic [PW-1:0] rel_pix;
    logic          in_line, in_pix;

    always_comb begin
        rel_line = line_n - cfg_img_line_off[fld_n];
        rel_pix  = pix_n  - cfg_img_pix_off[fld_n];
        in_line  = (line_n >= cfg_img_line_off[fld_n]) && (rel_line < cfg_img_lines[fld_n]);
        in_pix   = (pix_n  >= cfg_img_pix_off[fld_n])  && (rel_pix  < cfg_img_pixels[fld_n]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            img_pix  <= '0;
            img_line <= '0;
        end else begin
            active   <= in_line && in_pix;
            img_pix  <= (in_line && in_pix) ? rel_pix  : '0;
            img_line <= (in_line && in_pix) ? rel_line : '0;
        end
    end
endmodule

// File: rtl/video_timing_gen.sv
module video_timing_gen
    import vtg_pkg::*;
#(
    parameter int PW = PIX_W,
    parameter int LW = LINE_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [PW-1:0]             cfg_line_last,
    input  logic [LW-1:0]             cfg_frame_last,
    input  logic [PW-1:0]             cfg_hblank_on,
    input  logic [PW-1:0]             cfg_hblank_off,
    input  logic [PW-1:0]             cfg_hsync_on,
    input  logic [PW-1:0]             cfg_hsync_off,
    input  logic [NFIELD-1:0][LW-1:0] cfg_vblank_on_line,
    input  logic [NFIELD-1:0][PW-1:0] cfg_vblank_on_x,
    input  logic [NFIELD-1:0][LW-1:0] cfg_vblank_off_line,
    input  logic [NFIELD-1:0][PW-1:0] cfg_vblank_off_x,
    input  logic [NFIELD-1:0][LW-1:0] cfg_vsync_on_line,
    input  logic [NFIELD-1:0][PW-1:0] cfg_vsync_on_x,
    input  logic [NFIELD-1:0][LW-1:0] cfg_vsync_off_line,
    input  logic [NFIELD-1:0][PW-1:0] cfg_vsync_off_x,
    input  logic [LW-1:0]             cfg_fld_set_line,
    input  logic [LW-1:0]             cfg_fld_clr_line,
    input  logic [NFIELD-1:0][LW-1:0] cfg_img_line_off,
    input  logic [NFIELD-1:0][LW-1:0] cfg_img_lines,
    input  logic [NFIELD-1:0][PW-1:0] cfg_img_pix_off,
    input  logic [NFIELD-1:0][PW-1:0] cfg_img_pixels,
    output logic [PW-1:0]             frame_pix,
    output logic [LW-1:0]             frame_line,
    output logic [PW-1:0]             img_pix,
    output logic [LW-1:0]             img_line,
    output logic                      hblank,
    output logic                      hsync,
    output logic                      vblank,
    output logic                      vsync,
    output logic                      field,
    output logic                      img_active
);
    logic [PW-1:0]    pix_n;
    logic [LW-1:0]    line_n;
    edge_req_t [NFLAG-1:0] req;
    logic [NFLAG-1:0] flag_d, flag_q;
    logic [NFIELD-1:0] vb_on, vb_off, vs_on, vs_off;

    vtg_raster #(.PW(PW), .LW(LW)) u_raster (
        .clk, .rst, .cfg_line_last, .cfg_frame_last,
        .pix_q(frame_pix), .line_q(frame_line), .pix_n, .line_n
    );

    // Per-field vertical edge points: line number plus pixel on that line
    for (genvar f = 0; f < NFIELD; f++) begin : g_field_pts
        assign vb_on[f]  = (line_n == cfg_vblank_on_line[f])  && (pix_n == cfg_vblank_on_x[f]);
        assign vb_off[f] = (line_n == cfg_vblank_off_line[f]) && (pix_n == cfg_vblank_off_x[f]);
        assign vs_on[f]  = (line_n == cfg_vsync_on_line[f])   && (pix_n == cfg_vsync_on_x[f]);
        assign vs_off[f] = (line_n == cfg_vsync_off_line[f])  && (pix_n == cfg_vsync_off_x[f]);
    end

    always_comb begin
        req[FL_HBLANK] = '{on: pix_n == cfg_hblank_on, off: pix_n == cfg_hblank_off};
        req[FL_HSYNC]  = '{on: pix_n == cfg_hsync_on,  off: pix_n == cfg_hsync_off};
        req[FL_VBLANK] = '{on: |vb_on, off: |vb_off};
        req[FL_VSYNC]  = '{on: |vs_on, off: |vs_off};
        req[FL_FIELD]  = '{on:  (pix_n == '0) && (line_n == cfg_fld_set_line),
                           off: (pix_n == '0) && (line_n == cfg_fld_clr_line)};
    end

    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        vtg_edge_flag u_flag (
            .clk, .rst, .req(req[g]), .d(flag_d[g]), .q(flag_q[g])
        );
    end

    vtg_image_window #(.PW(PW), .LW(LW)) u_window (
        .clk, .rst, .pix_n, .line_n, .fld_n(flag_d[FL_FIELD]),
        .cfg_img_line_off, .cfg_img_lines, .cfg_img_pix_off, .cfg_img_pixels,
        .active(img_active), .img_pix, .img_line
    );

    assign hblank = flag_q[FL_HBLANK];
    assign hsync  = flag_q[FL_HSYNC];
    assign vblank = flag_q[FL_VBLANK];
    assign vsync  = flag_q[FL_VSYNC];
    assign field  = flag_q[FL_FIELD];
endmodule

// File: rtl/vtg_checker.sv
module vtg_checker
    import vtg_pkg::*;
#(
    parameter int PW = PIX_W,
    parameter int LW = LINE_W
) (
    input logic                      clk,
    input logic                      rst,
    input logic [PW-1:0]             cfg_line_last,
    input logic [LW-1:0]             cfg_frame_last,
    input logic [PW-1:0]             cfg_hblank_on,
    input logic [PW-1:0]             cfg_hsync_on,
    input logic [NFIELD-1:0][LW-1:0] cfg_vblank_on_line,
    input logic [NFIELD-1:0][PW-1:0] cfg_vblank_on_x,
    input logic [NFIELD-1:0][LW-1:0] cfg_vsync_off_line,
    input logic [NFIELD-1:0][PW-1:0] cfg_vsync_off_x,
    input logic [LW-1:0]             cfg_fld_set_line,
    input logic [NFIELD-1:0][PW-1:0] cfg_img_pix_off,
    input logic [PW-1:0]             frame_pix,
    input logic [LW-1:0]             frame_line,
    input logic [PW-1:0]             img_pix,
    input logic [LW-1:0]             img_line,
    input logic                      hblank,
    input logic                      hsync,
    input logic                      vblank,
    input logic                      vsync,
    input logic                      field,
    input logic                      img_active
);
    // Goes high once the raster has left the reset position
    logic moved;
    always_ff @(posedge clk) begin
        if (rst) moved <= 1'b0;
        else     moved <= 1'b1;
    end

    assert_pix_wrap_R1: assert property (@(posedge clk) disable iff (rst)
        frame_pix == cfg_line_last |=> frame_pix == '0);

    assert_pix_step_R1: assert property (@(posedge clk) disable iff (rst)
        frame_pix != cfg_line_last |=> frame_pix == PW'($past(frame_pix) + 1'b1));

    assert_line_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (frame_pix == cfg_line_last && frame_line == cfg_frame_last) |=> frame_line == LW'(1));

    assert_hblank_rise_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(hblank) |-> frame_pix == cfg_hblank_on);

    assert_hsync_rise_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(hsync) |-> frame_pix == cfg_hsync_on);

    assert_vblank_rise_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(vblank) |->
            ((frame_line == cfg_vblank_on_line[0] && frame_pix == cfg_vblank_on_x[0]) ||
             (frame_line == cfg_vblank_on_line[1] && frame_pix == cfg_vblank_on_x[1])));

    assert_vsync_fall_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(vsync) |->
            ((frame_line == cfg_vsync_off_line[0] && frame_pix == cfg_vsync_off_x[0]) ||
             (frame_line == cfg_vsync_off_line[1] && frame_pix == cfg_vsync_off_x[1])));

    assert_field_rise_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(field) |-> (frame_line == cfg_fld_set_line && frame_pix == '0));

    assert_img_left_edge_R8: assert property (@(posedge clk) disable iff (rst)
        img_active |-> frame_pix >= cfg_img_pix_off[field]);

    assert_img_idle_zero_R9: assert property (@(posedge clk) disable iff (rst)
        !img_active |-> (img_pix == '0 && img_line == '0));

    assert_on_wins_R10: assert property (@(posedge clk) disable iff (rst)
        (moved && frame_pix == cfg_hblank_on) |-> hblank);

    assert_reset_quiet_R12: assert property (@(posedge clk) disable iff (rst)
        !moved |-> !(hblank || hsync || vblank || vsync || field || img_active));
endmodule

bind video_timing_gen vtg_checker #(.PW(PW), .LW(LW)) u_vtg_checker (
    .clk, .rst, .cfg_line_last, .cfg_frame_last, .cfg_hblank_on, .cfg_hsync_on,
    .cfg_vblank_on_line, .cfg_vblank_on_x, .cfg_vsync_off_line, .cfg_vsync_off_x,
    .cfg_fld_set_line, .cfg_img_pix_off, .frame_pix, .frame_line, .img_pix,
    .img_line, .hblank, .hsync, .vblank, .vsync, .field, .img_active
);

// File: tb/video_timing_gen_bench.sv
`timescale 1ns/100ps
module video_timing_gen_bench;
    import vtg_pkg::*;
    localparam int PW = PIX_W;
    localparam int LW = LINE_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [PW-1:0] cfg_line_last, cfg_hblank_on, cfg_hblank_off, cfg_hsync_on, cfg_hsync_off;
    logic [LW-1:0] cfg_frame_last, cfg_fld_set_line, cfg_fld_clr_line;
    logic [NFIELD-1:0][LW-1:0] cfg_vblank_on_line, cfg_vblank_off_line, cfg_vsync_on_line, cfg_vsync_off_line;
    logic [NFIELD-1:0][PW-1:0] cfg_vblank_on_x, cfg_vblank_off_x, cfg_vsync_on_x, cfg_vsync_off_x;
    logic [NFIELD-1:0][LW-1:0] cfg_img_line_off, cfg_img_lines;
    logic [NFIELD-1:0][PW-1:0] cfg_img_pix_off, cfg_img_pixels;
    logic [PW-1:0] frame_pix, img_pix;
    logic [LW-1:0] frame_line, img_line;
    logic hblank, hsync, vblank, vsync, field, img_active;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    video_timing_gen u_video_timing_gen (.*);

    task automatic chk(string tag, string what, int got, int exp);
        n_vec++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    function automatic bit pt(int l, int p, int pl, int px);
        return (l == pl) && (p == px);
    endfunction

    function automatic bit upd(bit cur, bit on, bit off);
        if (on) return 1'b1;
        if (off) return 1'b0;
        return cur;
    endfunction

    // Runs two frames from reset; hb_tag and fld_tag name the requirement in play
    task automatic run_cfg(string hb_tag, string fld_tag);
        int lp = int'(cfg_line_last) + 1;
        int fl = int'(cfg_frame_last);
        bit e_hb = 0, e_hs = 0, e_vb = 0, e_vs = 0, e_fd = 0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // Reset state (R2, R12)
        chk("R2", "reset pix", int'(frame_pix), 0);
        chk("R2", "reset line", int'(frame_line), 1);
        chk("R12", "reset flags", int'({hblank, hsync, vblank, vsync, field, img_active}), 0);
        chk("R2", "reset img", int'(img_pix) + int'(img_line), 0);
        for (int k = 1; k <= 2 * lp * fl; k++) begin
            int p, l, f, lo, ln, po, pn;
            bit act;
            @(negedge clk);
            p = k % lp;
            l = 1 + (k / lp) % fl;
            e_hb = upd(e_hb, p == int'(cfg_hblank_on), p == int'(cfg_hblank_off));
            e_hs = upd(e_hs, p == int'(cfg_hsync_on), p == int'(cfg_hsync_off));
            e_vb = upd(e_vb,
                pt(l, p, cfg_vblank_on_line[0], cfg_vblank_on_x[0]) || pt(l, p, cfg_vblank_on_line[1], cfg_vblank_on_x[1]),
                pt(l, p, cfg_vblank_off_line[0], cfg_vblank_off_x[0]) || pt(l, p, cfg_vblank_off_line[1], cfg_vblank_off_x[1]));
            e_vs = upd(e_vs,
                pt(l, p, cfg_vsync_on_line[0], cfg_vsync_on_x[0]) || pt(l, p, cfg_vsync_on_line[1], cfg_vsync_on_x[1]),
                pt(l, p, cfg_vsync_off_line[0], cfg_vsync_off_x[0]) || pt(l, p, cfg_vsync_off_line[1], cfg_vsync_off_x[1]));
            e_fd = upd(e_fd, pt(l, p, cfg_fld_set_line, 0), pt(l, p, cfg_fld_clr_line, 0));
            f  = int'(e_fd);
            lo = int'(cfg_img_line_off[f]);
            ln = int'(cfg_img_lines[f]);
            po = int'(cfg_img_pix_off[f]);
            pn = int'(cfg_img_pixels[f]);
            act = (l >= lo) && (l < lo + ln) && (p >= po) && (p < po + pn);
            chk("R1", "frame_pix", int'(frame_pix), p);
            chk("R2", "frame_line", int'(frame_line), l);
            chk(hb_tag, "hblank", int'(hblank), int'(e_hb));
            chk("R4", "hsync", int'(hsync), int'(e_hs));
            chk("R5", "vblank", int'(vblank), int'(e_vb));
            chk("R6", "vsync", int'(vsync), int'(e_vs));
            chk(fld_tag, "field", int'(field), int'(e_fd));
            chk("R8", "img_active", int'(img_active), int'(act));
            chk("R9", "img_pix", int'(img_pix), act ? p - po : 0);
            chk("R9", "img_line", int'(img_line), act ? l - lo : 0);
        end
    endtask

    initial begin
        // Config A: interlaced, wrapping hblank, mid-line vertical edges (R3, R7)
        cfg_line_last = 19; cfg_frame_last = 11;
        cfg_hblank_on = 14; cfg_hblank_off = 2;
        cfg_hsync_on = 16;  cfg_hsync_off = 18;
        cfg_vblank_on_line  = {LW'(6), LW'(1)}; cfg_vblank_on_x  = {PW'(10), PW'(5)};
        cfg_vblank_off_line = {LW'(8), LW'(3)}; cfg_vblank_off_x = {PW'(10), PW'(0)};
        cfg_vsync_on_line   = {LW'(6), LW'(1)}; cfg_vsync_on_x   = {PW'(18), PW'(8)};
        cfg_vsync_off_line  = {LW'(7), LW'(2)}; cfg_vsync_off_x  = {PW'(18), PW'(8)};
        cfg_fld_set_line = 6; cfg_fld_clr_line = 1;
        cfg_img_line_off = {LW'(8), LW'(3)}; cfg_img_lines  = {LW'(3), LW'(3)};
        cfg_img_pix_off  = {PW'(4), PW'(3)}; cfg_img_pixels = {PW'(10), PW'(10)};
        run_cfg("R3", "R7");

        // Config B: progressive, coincident hblank points (R10, R11)
        rst = 1'b1;
        cfg_hblank_on = 5; cfg_hblank_off = 5;
        cfg_hsync_on = 0;  cfg_hsync_off = 10;
        cfg_vblank_on_line  = {LW'(11), LW'(11)}; cfg_vblank_on_x  = {PW'(0), PW'(0)};
        cfg_vblank_off_line = {LW'(2), LW'(2)};   cfg_vblank_off_x = {PW'(0), PW'(0)};
        cfg_vsync_on_line   = {LW'(11), LW'(11)}; cfg_vsync_on_x   = {PW'(3), PW'(3)};
        cfg_vsync_off_line  = {LW'(1), LW'(1)};   cfg_vsync_off_x  = {PW'(3), PW'(3)};
        cfg_fld_set_line = 20; cfg_fld_clr_line = 1;
        cfg_img_line_off = {LW'(1), LW'(2)}; cfg_img_lines  = {LW'(2), LW'(9)};
        cfg_img_pix_off  = {PW'(17), PW'(0)}; cfg_img_pixels = {PW'(2), PW'(16)};
        run_cfg("R10", "R11");

        // Config C: long short frame, window touching line end (R8, R9)
        rst = 1'b1;
        cfg_line_last = 31; cfg_frame_last = 3;
        cfg_hblank_on = 24; cfg_hblank_off = 31;
        cfg_hsync_on = 26;  cfg_hsync_off = 1;
        cfg_vblank_on_line  = {LW'(2), LW'(3)}; cfg_vblank_on_x  = {PW'(16), PW'(30)};
        cfg_vblank_off_line = {LW'(2), LW'(1)}; cfg_vblank_off_x = {PW'(20), PW'(2)};
        cfg_vsync_on_line   = {LW'(3), LW'(1)}; cfg_vsync_on_x   = {PW'(0), PW'(31)};
        cfg_vsync_off_line  = {LW'(3), LW'(2)}; cfg_vsync_off_x  = {PW'(4), PW'(0)};
        cfg_fld_set_line = 2; cfg_fld_clr_line = 3;
        cfg_img_line_off = {LW'(2), LW'(1)}; cfg_img_lines  = {LW'(2), LW'(1)};
        cfg_img_pix_off  = {PW'(0), PW'(20)}; cfg_img_pixels = {PW'(1), PW'(12)};
        run_cfg("R3", "R7");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule